// File: doc/BRIEF.md
# Video Input Clamp Sequencer

This block steers the DC level of a composite video input into the range of the ADC that digitizes it, and keeps it there. It drives two external analog switches. One pulls the input toward the bottom reference (clamp-low). The other pulls it toward the top rail (clamp-high). The sequence starts at reset with coarse clamping. Once lines and underflow behave, it moves to clamping timed from the horizontal sync edge. When the horizontal PLL reports lock, clamping follows a window taken from the PLL's pixel counter.

The sequencer runs on the sample clock and watches several inputs: the 7-bit ADC sample, the ADC underflow flag, a sync-edge strobe, a line strobe, the lock flag and the sync window. While the sequence is in its edge-timed or locked phase, each line must contain at least one sample below midscale. A line without one restarts the sequence. A long, deep underflow fires a short clamp-high pulse. When the input carries only a sync signal, a disable input silences both switches.

Top module: `vclamp_sequencer`

## Requirements
- R1: While reset is high both outputs are low. After reset is released the sequence is in the coarse phase, so clamp_lo is high from the first cycle after release and clamp_hi is low.
- R2: In the coarse phase clamp_lo stays high through LINES_COARSE (6) line strobes. It is still high in the cycle after the sixth strobe and low one cycle later, when the underflow-seeking phase begins.
- R3: In the underflow-seeking phase, a run of underflow-flag samples longer than UFLOW_RUN (30) starts a clamp_hi pulse of HIGH_LEN (8) cycles. The 31st consecutive flagged sample causes clamp_hi to rise one cycle later. A run of exactly 30 samples has no effect.
- R4: The seeking phase moves to the edge-timed phase only after one full line, strobe to strobe, in which no clamp_hi pulse was started. The partial line in which the phase is entered does not count, and a line with a pulse keeps the sequence in the seeking phase.
- R5: In the edge-timed phase, a sync-edge strobe sampled at edge E raises clamp_lo after edge E+EDGE_DELAY+1 (E+28) for LOW_LEN (16) cycles.
- R6: From the edge-timed phase, hpll_lock high enters the locked phase. In that phase clamp_lo equals sync_win delayed by one cycle and sync-edge strobes have no effect. Lock low returns the sequence to the edge-timed phase.
- R7: In the edge-timed and locked phases, a line strobe ends a line. If no sample below midscale (2^(SAMPLE_W-1) = 64) occurred from the cycle after the previous strobe through the strobe cycle, the sequence restarts in the coarse phase.
- R8: In the edge-timed and locked phases, clamp_hi fires only for a deep underflow: the flag high together with a sample value of 0 for more than 30 consecutive samples. The flag alone with a nonzero sample has no effect.
- R9: In the coarse phase underflow never produces clamp_hi.
- R10: clamp_lo and clamp_hi are never high together, and an active clamp_hi pulse overrides clamp_lo.
- R11: With clamp_dis high both outputs are low from the next cycle and the sequence is held at the start of the coarse phase. After release it runs the full coarse phase again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| clamp_dis | input | 1 | Suppresses all clamping and holds the sequence at its start |
| adc_sample | input | SAMPLE_W | Digitized input sample |
| adc_uflow | input | 1 | ADC below-range flag |
| hsync_edge | input | 1 | One-cycle strobe at the horizontal sync leading edge |
| line_strobe | input | 1 | One-cycle strobe at each line boundary |
| hpll_lock | input | 1 | Horizontal PLL locked flag |
| sync_win | input | 1 | Clamp window from the PLL pixel counter (first half of sync) |
| clamp_lo | output | 1 | Drive for the switch to the bottom reference |
| clamp_hi | output | 1 | Drive for the switch to the top rail |

## Verification
The bench builds the block with its default parameters: 30-cycle underflow runs, a 27-cycle sync delay, 8- and 16-cycle pulses and six coarse lines. Because the bench supplies the line strobes itself, lines are only a few cycles long. All four phases, every restart path and the exact pulse edges therefore fit into a few thousand cycles. The 30/31-sample underflow boundary and the 63/64 midscale boundary are both exercised directly at these values.

// File: rtl/vclamp_pkg.sv
package vclamp_pkg;

  // Phases of the clamp sequence, in the order the sequence advances.
  typedef enum logic [1:0] {
    PH_COARSE = 2'd0,  // continuous clamp to bottom reference
    PH_SEEK   = 2'd1,  // clamp-high on long underflow
    PH_EDGE   = 2'd2,  // delayed pulse after sync edge
    PH_LOCK   = 2'd3   // pulse inside the PLL sync window
  } clamp_phase_e;

endpackage

// File: rtl/vclamp_run_detect.sv
// Fires once a qualifier has stayed high for more than RUN_CYC samples,
// then starts counting a fresh run.
module vclamp_run_detect #(
  parameter int unsigned RUN_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic qual,
  output logic fire
);
  localparam int unsigned CW = $clog2(RUN_CYC + 1);

  logic [CW-1:0] run_q;

  assign fire = qual && (run_q == CW'(RUN_CYC));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q <= '0;
    end else if (!qual || fire) begin
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R3: a firing needs the qualifier in the previous sample too
  p_fire_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && !$past(clr) && !$past(rst)) |-> $past(qual));

endmodule

// File: rtl/vclamp_pulse.sv
// Fixed-length pulse, optionally started a fixed number of cycles after
// its trigger.
module vclamp_pulse #(
  parameter int unsigned LEN   = 8,
  parameter int unsigned DELAY = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trig,
  output logic active
);
  localparam int unsigned LW = $clog2(LEN + 1);

  logic          start;
  logic [LW-1:0] len_q;

  generate
    if (DELAY == 0) begin : g_direct
      assign start = trig;
    end else begin : g_delayed
      localparam int unsigned DW = $clog2(DELAY + 1);
      logic [DW-1:0] dly_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          dly_q <= '0;
        end else if (trig) begin
          dly_q <= DW'(DELAY);
        end else if (dly_q != '0) begin
          dly_q <= dly_q - 1'b1;
        end
      end
      assign start = (dly_q == DW'(1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      len_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      len_q  <= LW'(LEN - 1);
    end else if (len_q != '0) begin
      len_q <= len_q - 1'b1;
    end else begin
      active <= 1'b0;
    end
  end

  // R3: a pulse whose length count has run out ends on the next edge
  p_pulse_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (active && len_q == '0 && !start) |=> !active);

endmodule

// File: rtl/vclamp_line_watch.sv
// Flags a line that ended without any sample below midscale.
module vclamp_line_watch #(
  parameter int unsigned SAMPLE_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                line_strobe,
  output logic                quiet_line
);
  localparam logic [SAMPLE_W-1:0] MIDSCALE = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic low_now;
  logic seen_q;

  assign low_now    = (sample < MIDSCALE);
  assign quiet_line = line_strobe && !seen_q && !low_now;

  always_ff @(posedge clk) begin
    if (rst || line_strobe) begin
      seen_q <= 1'b0;
    end else if (low_now) begin
      seen_q <= 1'b1;
    end
  end

  // R7: a low sample inside a line prevents the quiet verdict at its end
  p_low_blocks_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (low_now && !line_strobe) |=> !quiet_line);

endmodule

// File: rtl/vclamp_sequencer.sv
module vclamp_sequencer
  import vclamp_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 7,
  parameter int unsigned LINES_COARSE = 6,
  parameter int unsigned UFLOW_RUN    = 30,
  parameter int unsigned EDGE_DELAY   = 27,
  parameter int unsigned HIGH_LEN     = 8,
  parameter int unsigned LOW_LEN      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clamp_dis,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic                adc_uflow,
  input  logic                hsync_edge,
  input  logic                line_strobe,
  input  logic                hpll_lock,
  input  logic                sync_win,
  output logic                clamp_lo,
  output logic                clamp_hi
);
  localparam int unsigned LCW = $clog2(LINES_COARSE + 1);

  clamp_phase_e   phase_q, phase_d;
  logic [LCW-1:0] line_cnt_q;
  logic           clean_q;
  logic           quiet_line;
  logic           run_qual;
  logic           hi_fire;
  logic           hi_active;
  logic           lo_pulse;
  logic           lo_sel;
  logic           track;

  assign track = (phase_q == PH_EDGE) || (phase_q == PH_LOCK);

  vclamp_line_watch #(.SAMPLE_W(SAMPLE_W)) u_watch (
    .clk(clk), .rst(rst), .sample(adc_sample),
    .line_strobe(line_strobe), .quiet_line(quiet_line)
  );

  // Underflow qualifier: plain flag while seeking, deep underflow later.
  always_comb begin
    case (phase_q)
      PH_SEEK:          run_qual = adc_uflow;
      PH_EDGE, PH_LOCK: run_qual = adc_uflow && (adc_sample == '0);
      default:          run_qual = 1'b0;
    endcase
  end

  vclamp_run_detect #(.RUN_CYC(UFLOW_RUN)) u_run (
    .clk(clk), .rst(rst), .clr(phase_d == PH_COARSE),
    .qual(run_qual), .fire(hi_fire)
  );

  vclamp_pulse #(.LEN(HIGH_LEN), .DELAY(0)) u_hi_pulse (
    .clk(clk), .rst(rst), .clr(phase_d == PH_COARSE),
    .trig(hi_fire), .active(hi_active)
  );

  vclamp_pulse #(.LEN(LOW_LEN), .DELAY(EDGE_DELAY)) u_lo_pulse (
    .clk(clk), .rst(rst), .clr(phase_d != PH_EDGE),
    .trig(hsync_edge && (phase_q == PH_EDGE)), .active(lo_pulse)
  );

  // Phase transitions; the line watchdog outranks lock changes.
  always_comb begin
    phase_d = phase_q;
    if (clamp_dis) begin
      phase_d = PH_COARSE;
    end else begin
      case (phase_q)
        PH_COARSE:
          if (line_strobe && line_cnt_q == LCW'(LINES_COARSE - 1)) phase_d = PH_SEEK;
        PH_SEEK:
          if (line_strobe && clean_q && !hi_fire) phase_d = PH_EDGE;
        PH_EDGE:
          if (quiet_line)     phase_d = PH_COARSE;
          else if (hpll_lock) phase_d = PH_LOCK;
        PH_LOCK:
          if (quiet_line)      phase_d = PH_COARSE;
          else if (!hpll_lock) phase_d = PH_EDGE;
        default: phase_d = PH_COARSE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_COARSE;
      line_cnt_q <= '0;
      clean_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (phase_q != PH_COARSE || clamp_dis) line_cnt_q <= '0;
      else if (line_strobe)                  line_cnt_q <= line_cnt_q + 1'b1;
      if (phase_q != PH_SEEK || hi_fire) clean_q <= 1'b0;
      else if (line_strobe)              clean_q <= 1'b1;
    end
  end

  always_comb begin
    case (phase_q)
      PH_COARSE: lo_sel = 1'b1;
      PH_EDGE:   lo_sel = lo_pulse;
      PH_LOCK:   lo_sel = sync_win;
      default:   lo_sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_lo <= 1'b0;
      clamp_hi <= 1'b0;
    end else begin
      clamp_lo <= !clamp_dis && lo_sel && !hi_active;
      clamp_hi <= !clamp_dis && hi_active;
    end
  end

  // R10: the two switches are never closed together
  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(clamp_lo && clamp_hi));

  // R11: disable silences both outputs on the next cycle
  p_disable_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    clamp_dis |=> (!clamp_lo && !clamp_hi));

  // R2: the coarse phase holds clamp-low
  p_coarse_low_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_COARSE && !clamp_dis) |=> clamp_lo);

  // R9: no clamp-high source is live in the coarse phase
  p_coarse_no_high_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_COARSE) |-> !hi_active);

  // R7: a quiet line while tracking restarts the sequence
  p_quiet_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (track && quiet_line && !clamp_dis) |=> (phase_q == PH_COARSE));

  // R6: loss of lock falls back to edge timing
  p_lock_lost_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LOCK && !clamp_dis && !quiet_line && !hpll_lock) |=> (phase_q == PH_EDGE));

endmodule

// File: tb/vclamp_sequencer_test.sv
module vclamp_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clamp_dis = 1'b0;
  logic [6:0] adc_sample = 7'd100;
  logic       adc_uflow = 1'b0;
  logic       hsync_edge = 1'b0;
  logic       line_strobe = 1'b0;
  logic       hpll_lock = 1'b0;
  logic       sync_win = 1'b0;
  logic       clamp_lo, clamp_hi;

  int checks = 0;
  int errors = 0;
  int excl_bad = 0;

  always #4 clk = ~clk;

  vclamp_sequencer uut (
    .clk(clk), .rst(rst), .clamp_dis(clamp_dis), .adc_sample(adc_sample),
    .adc_uflow(adc_uflow), .hsync_edge(hsync_edge), .line_strobe(line_strobe),
    .hpll_lock(hpll_lock), .sync_win(sync_win),
    .clamp_lo(clamp_lo), .clamp_hi(clamp_hi)
  );

  always @(negedge clk) if (!rst && clamp_lo && clamp_hi) excl_bad++;

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic strobe();
    line_strobe = 1'b1;
    tick();
    line_strobe = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; clamp_dis = 0; adc_sample = 7'd100; adc_uflow = 0;
    hsync_edge = 0; line_strobe = 0; hpll_lock = 0; sync_win = 0;
    idle(3);
    expect_bit("R1 lo in reset", clamp_lo, 1'b0);
    expect_bit("R1 hi in reset", clamp_hi, 1'b0);
    rst = 1'b0;
    tick();
    expect_bit("R1 lo after release", clamp_lo, 1'b1);
    expect_bit("R1 hi after release", clamp_hi, 1'b0);
  endtask

  task automatic to_seek();
    do_reset();
    repeat (6) begin idle(5); strobe(); end
    idle(2);
  endtask

  task automatic to_edge();
    to_seek();
    strobe(); idle(5); strobe(); idle(2);
  endtask

  // Sync edge, then watch the delayed clamp-low window edges.
  task automatic hsync_probe(input string req, input logic exp);
    hsync_edge = 1'b1; tick(); hsync_edge = 1'b0;
    for (int j = 1; j <= 45; j++) begin
      tick();
      if (j == 27) expect_bit({req, " before window"}, clamp_lo, 1'b0);
      if (j == 28) expect_bit({req, " window start"}, clamp_lo, exp);
      if (j == 43) expect_bit({req, " window end"}, clamp_lo, exp);
      if (j == 44) expect_bit({req, " after window"}, clamp_lo, 1'b0);
    end
  endtask

  task automatic t_coarse();
    do_reset();
    adc_uflow = 1; adc_sample = 0;
    idle(40);
    expect_bit("R9 no high in coarse", clamp_hi, 1'b0);
    expect_bit("R2 low held", clamp_lo, 1'b1);
    adc_uflow = 0; adc_sample = 7'd100;
    repeat (5) begin idle(3); strobe(); end
    idle(2);
    expect_bit("R2 low after five lines", clamp_lo, 1'b1);
    strobe();
    expect_bit("R2 low right after sixth", clamp_lo, 1'b1);
    tick();
    expect_bit("R2 low released", clamp_lo, 1'b0);
  endtask

  task automatic t_seek_uflow();
    to_seek();
    adc_uflow = 1; idle(30); adc_uflow = 0; idle(12);
    expect_bit("R3 run of 30 ignored", clamp_hi, 1'b0);
    adc_uflow = 1; idle(31);
    expect_bit("R3 not yet high", clamp_hi, 1'b0);
    adc_uflow = 0;
    tick();
    expect_bit("R3 high starts", clamp_hi, 1'b1);
    expect_bit("R3 low off while seeking", clamp_lo, 1'b0);
    idle(7);
    expect_bit("R3 high last cycle", clamp_hi, 1'b1);
    tick();
    expect_bit("R3 high ended", clamp_hi, 1'b0);
  endtask

  task automatic t_seek_exit();
    to_seek();
    strobe();
    adc_uflow = 1; idle(31); adc_uflow = 0; idle(10);
    strobe(); idle(3);
    hsync_probe("R4 stays seeking after pulsed line", 1'b0);
    strobe(); idle(2);
    hsync_probe("R4 edge phase after clean line", 1'b1);
  endtask

  task automatic t_edge_pulse();
    to_edge();
    hsync_probe("R5 delayed low", 1'b1);
  endtask

  task automatic t_lock();
    to_edge();
    hpll_lock = 1; tick();
    sync_win = 1; tick();
    expect_bit("R6 follows window", clamp_lo, 1'b1);
    tick();
    expect_bit("R6 follows window held", clamp_lo, 1'b1);
    sync_win = 0; tick();
    expect_bit("R6 window closed", clamp_lo, 1'b0);
    hsync_probe("R6 sync edge ignored when locked", 1'b0);
    hpll_lock = 0; tick(); idle(1);
    hsync_probe("R6 back to edge timing", 1'b1);
  endtask

  task automatic t_watchdog();
    to_edge();
    idle(4); adc_sample = 7'd63; tick(); adc_sample = 7'd100; idle(4);
    strobe(); idle(3);
    expect_bit("R7 line with 63 keeps phase", clamp_lo, 1'b0);
    adc_sample = 7'd64; idle(6);
    strobe();
    expect_bit("R7 restart not yet visible", clamp_lo, 1'b0);
    tick();
    expect_bit("R7 restart to coarse", clamp_lo, 1'b1);
    idle(5);
    expect_bit("R7 coarse held", clamp_lo, 1'b1);
    adc_sample = 7'd100;
  endtask

  task automatic t_deep();
    to_edge();
    hpll_lock = 1; tick();
    sync_win = 1; adc_uflow = 1; adc_sample = 7'd5;
    idle(40);
    expect_bit("R8 shallow underflow ignored", clamp_hi, 1'b0);
    expect_bit("R8 window low kept", clamp_lo, 1'b1);
    adc_sample = 7'd0; idle(31);
    expect_bit("R8 not yet high", clamp_hi, 1'b0);
    adc_uflow = 0; adc_sample = 7'd100;
    tick();
    expect_bit("R8 deep underflow high", clamp_hi, 1'b1);
    expect_bit("R10 high overrides low", clamp_lo, 1'b0);
    idle(8);
    expect_bit("R8 high ended", clamp_hi, 1'b0);
    expect_bit("R10 low resumes", clamp_lo, 1'b1);
    sync_win = 0; hpll_lock = 0;
  endtask

  task automatic t_disable();
    int seen;
    seen = 0;
    to_edge();
    hsync_edge = 1; tick(); hsync_edge = 0;
    clamp_dis = 1; adc_uflow = 1; adc_sample = 0;
    tick();
    expect_bit("R11 lo off", clamp_lo, 1'b0);
    expect_bit("R11 hi off", clamp_hi, 1'b0);
    repeat (40) begin tick(); if (clamp_lo || clamp_hi) seen++; end
    expect_bit("R11 silent while disabled", (seen != 0), 1'b0);
    clamp_dis = 0; adc_uflow = 0; adc_sample = 7'd100;
    tick();
    expect_bit("R11 restarts coarse", clamp_lo, 1'b1);
    repeat (5) begin idle(3); strobe(); end
    idle(2);
    expect_bit("R11 full coarse phase again", clamp_lo, 1'b1);
  endtask

  initial begin
    t_coarse();
    t_seek_uflow();
    t_seek_exit();
    t_edge_pulse();
    t_lock();
    t_watchdog();
    t_deep();
    t_disable();
    expect_bit("R10 never both high", (excl_bad != 0), 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule